// File: doc/BRIEF.md
# MDIO Management Master with Command Slot

This block lets software reach the management registers of external Ethernet PHYs over a two-wire MDIO link. Software writes one 32-bit command word through a small register bus. The word names the operation, the PHY, the PHY register and, for a write, the 16-bit value. The block holds the word in a single pending slot. When the serial bus is free, it sends the word as a Clause 22 management frame on MDC/MDIO.

For a read, the PHY drives the data phase. The block shifts the 16 returned bits into a result register and adds a 2-bit error field, which is set when the PHY fails to answer during the turnaround. A status register shows two separate conditions: a command is waiting in the slot, and a frame is on the wire. Software can therefore queue the next command as soon as the slot empties, which happens while the previous frame is still being sent. A read result is valid once the on-the-wire flag drops.

The pad is driven through an output value and an output-enable, so an external tri-state buffer forms the bidirectional MDIO pin. MDC is made by dividing the system clock.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status reads 0, the result register reads 0, MDC is low and MDIO is released (output-enable low).
- R2: The register bus decodes offset 0x0 as status (bit 2 = command waiting, bit 3 = frame on wire, other bits 0), offset 0x8 as command (write only) and offset 0xC as result (bits 15:0 data, bits 17:16 error, other bits 0). A write to any other offset has no effect.
- R3: A command word has bit 31 = valid, bit 1 = write, bit 2 = read, PHY address in bits 29:25, register address in bits 24:20 and write data in bits 19:4. A well-formed command written to 0x8 sets status bit 2 in the next cycle.
- R4: A command with bit 31 clear, or with both or neither of bits 1 and 2 set, is ignored: status stays 0 and no frame is sent.
- R5: A command written while status bit 2 is set is ignored and never sent.
- R6: When a frame starts, status bit 2 clears and status bit 3 is set in the same cycle. A new command can then be accepted while bit 3 is still high.
- R7: Each frame on MDIO, with bits launched after MDC falls, is 32 ones, start 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register address, 2 turnaround bits and 16 data bits, all fields MSB first.
- R8: In a write frame the turnaround is 10, the data bits are the command's write data, and MDIO is driven for all 64 bits.
- R9: In a read frame MDIO is released from the first turnaround bit through the last data bit. The 16 bits sampled on MDC rising edges land MSB first in result bits 15:0.
- R10: Result bits 17:16 both read 1 if the PHY held MDIO high during the second turnaround bit of a read, and both read 0 after a read that the PHY answered correctly.
- R11: MDC has a period of 2*HALF_DIV system clocks with equal high and low times. MDIO and its enable change only at the clock edge on which MDC falls.
- R12: Status bit 3 clears after the last data bit. The result register holds the read value by the first cycle in which bit 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register bus byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock to PHYs |
| mdio_out | output | 1 | MDIO value to pad driver |
| mdio_oe | output | 1 | MDIO pad output-enable |
| mdio_in | input | 1 | MDIO value from pad |

## Verification
The bench queues a second command while a frame is running and then a third while the slot is full. A design that linked the slot to the busy flag would refuse the second command, and one that overwrote the slot would send the third command's PHY address. Malformed commands (valid clear, both operation bits set, no operation bit set) must leave the status idle. A decoder that checked only one bit would start a frame. A PHY model answers reads, once with a stuck-high turnaround. A design that sampled on the wrong MDC edge or at the wrong bit index would shift the data by one bit or miss the error. One that failed to clear the error field would carry it into the next good read.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared constants and types for the MDIO management master.
// Assumes a byte-offset register bus with 4 address bits.
package mdio_mgmt_pkg;

    localparam logic [3:0] OFS_STATUS = 4'h0;
    localparam logic [3:0] OFS_CMD    = 4'h8;
    localparam logic [3:0] OFS_RESULT = 4'hC;

    localparam int CMD_VALID_BIT = 31;
    localparam int CMD_WR_BIT    = 1;
    localparam int CMD_RD_BIT    = 2;
    localparam int CMD_PHY_LSB   = 25;
    localparam int CMD_REG_LSB   = 20;
    localparam int CMD_DAT_LSB   = 4;

    localparam int STAT_WAIT_BIT = 2;
    localparam int STAT_BUSY_BIT = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mgmt_op_e;

    typedef struct packed {
        mgmt_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mgmt_cmd_t;

endpackage

// File: rtl/mdio_clk_div.sv
// Module: MDC generator. Divides clk by 2*HALF_DIV and emits one-cycle
// ticks on the cycle before MDC rises or falls.
// Assumes HALF_DIV >= 1. MDC is low out of reset.
module mdio_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap_w;

    assign wrap_w    = (cnt_q == LAST);
    assign rise_tick = wrap_w & ~mdc;
    assign fall_tick = wrap_w &  mdc;

    // Count system clocks per half period and toggle MDC on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap_w) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_cmd_slot.sv
// Module: single-entry command slot. Decodes writes to the command offset,
// accepts well-formed commands only while empty, and empties on take.
// Assumes take is only raised while pending is high.
module mdio_cmd_slot
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        take,
    output logic        pending,
    output mgmt_cmd_t   cmd_q
);

    logic      is_wr_op, is_rd_op, accept_w;
    mgmt_cmd_t decoded_w;
    logic      unused_bits;

    assign unused_bits = ^{wr_data[30], wr_data[3], wr_data[0]};

    assign is_wr_op = wr_data[CMD_WR_BIT];
    assign is_rd_op = wr_data[CMD_RD_BIT];

    // Accept only a valid command with exactly one operation, into an empty slot.
    assign accept_w = wr_en && (wr_addr == OFS_CMD) && wr_data[CMD_VALID_BIT]
                      && (is_wr_op ^ is_rd_op) && !pending;

    // Unpack the command fields from the bus word.
    always_comb begin
        decoded_w.op    = is_rd_op ? OP_READ : OP_WRITE;
        decoded_w.phy   = wr_data[CMD_PHY_LSB +: 5];
        decoded_w.regad = wr_data[CMD_REG_LSB +: 5];
        decoded_w.wdata = wr_data[CMD_DAT_LSB +: 16];
    end

    // Fill the slot on accept, empty it when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cmd_q   <= '0;
        end else if (accept_w) begin
            pending <= 1'b1;
            cmd_q   <= decoded_w;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer. Takes a pending command on an MDC falling tick,
// shifts the frame out MSB first, releases MDIO for read turnaround/data,
// samples MDIO on rising ticks and updates the result when the frame ends.
// Assumes rise_tick and fall_tick are never high together.
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        pending,
    input  mgmt_cmd_t   cmd,
    input  logic        mdio_in,
    output logic        take,
    output logic        busy,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic [1:0]  rd_err
);

    localparam int FL   = PRE_LEN + 32;
    localparam int IW   = $clog2(FL);
    localparam logic [IW-1:0] LAST_IDX = IW'(FL - 1);
    localparam logic [IW-1:0] TA_IDX   = IW'(PRE_LEN + 14);
    localparam logic [IW-1:0] TA2_IDX  = IW'(PRE_LEN + 15);
    localparam logic [IW-1:0] DAT_IDX  = IW'(PRE_LEN + 16);

    logic [FL-1:0] frame_w;
    logic [FL-1:0] shreg_q;
    logic [IW-1:0] idx_q, nxt_idx_w;
    logic          is_rd_q, ta_bad_q;
    logic [15:0]   rx_q;
    logic [1:0]    opcode_w;
    logic [15:0]   wd_w;

    assign opcode_w  = (cmd.op == OP_READ) ? 2'b10 : 2'b01;
    assign wd_w      = (cmd.op == OP_READ) ? 16'hFFFF : cmd.wdata;
    assign frame_w   = {{PRE_LEN{1'b1}}, 2'b01, opcode_w, cmd.phy, cmd.regad, 2'b10, wd_w};
    assign take      = !busy && pending && fall_tick;
    assign nxt_idx_w = idx_q + 1'b1;

    // Launch, shift and close frames; sample read bits on rising ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
            shreg_q  <= '0;
            idx_q    <= '0;
            is_rd_q  <= 1'b0;
            ta_bad_q <= 1'b0;
            rx_q     <= '0;
            rd_data  <= '0;
            rd_err   <= '0;
        end else if (!busy) begin
            if (take) begin
                busy     <= 1'b1;
                mdio_out <= frame_w[FL-1];
                mdio_oe  <= 1'b1;
                shreg_q  <= frame_w << 1;
                idx_q    <= '0;
                is_rd_q  <= (cmd.op == OP_READ);
                ta_bad_q <= 1'b0;
                rx_q     <= '0;
            end
        end else begin
            if (fall_tick) begin
                if (idx_q == LAST_IDX) begin
                    busy     <= 1'b0;
                    mdio_out <= 1'b1;
                    mdio_oe  <= 1'b0;
                    if (is_rd_q) begin
                        rd_data <= rx_q;
                        rd_err  <= {ta_bad_q, ta_bad_q};
                    end
                end else begin
                    idx_q    <= nxt_idx_w;
                    mdio_out <= shreg_q[FL-1];
                    shreg_q  <= shreg_q << 1;
                    mdio_oe  <= !(is_rd_q && (nxt_idx_w >= TA_IDX));
                end
            end
            if (rise_tick && is_rd_q) begin
                if (idx_q == TA2_IDX) begin
                    ta_bad_q <= mdio_in;
                end
                if (idx_q >= DAT_IDX) begin
                    rx_q <= {rx_q[14:0], mdio_in};
                end
            end
        end
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
// Module: top of the MDIO management master. Register bus front end,
// command slot, MDC divider and frame sequencer.
// Assumes an external tri-state pad built from mdio_out/mdio_oe.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);

    logic        rise_tick_w, fall_tick_w;
    logic        pending_w, busy_w, take_w;
    mgmt_cmd_t   cmd_w;
    logic [15:0] rd_data_w;
    logic [1:0]  rd_err_w;

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick_w),
        .fall_tick (fall_tick_w)
    );

    mdio_cmd_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .take    (take_w),
        .pending (pending_w),
        .cmd_q   (cmd_w)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_tick (rise_tick_w),
        .fall_tick (fall_tick_w),
        .pending   (pending_w),
        .cmd       (cmd_w),
        .mdio_in   (mdio_in),
        .take      (take_w),
        .busy      (busy_w),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data_w),
        .rd_err    (rd_err_w)
    );

    // Read mux for status and result offsets.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: begin
                reg_rdata[STAT_WAIT_BIT] = pending_w;
                reg_rdata[STAT_BUSY_BIT] = busy_w;
            end
            OFS_RESULT: reg_rdata[17:0] = {rd_err_w, rd_data_w};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_checker.sv
// Module: property checker for mdio_mgmt_master, attached by bind.
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  reg_addr,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic        pending,
    input logic        busy,
    input logic        mdc,
    input logic        rise_tick,
    input logic        fall_tick,
    input logic        mdio_out,
    input logic        mdio_oe
);

    logic good_cmd, bad_cmd;
    logic unused_bits;

    assign unused_bits = ^{reg_wdata[30:3], reg_wdata[0]};
    assign good_cmd = reg_wr && (reg_addr == 4'h8) && reg_wdata[31] && (reg_wdata[2] != reg_wdata[1]);
    assign bad_cmd  = reg_wr && (reg_addr == 4'h8) && !(reg_wdata[31] && (reg_wdata[2] != reg_wdata[1]));

    // R3: a well-formed command into an empty slot is pending next cycle
    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        good_cmd && !pending |=> pending);

    // R4: a malformed command leaves an empty slot empty
    p_reject_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd && !pending |=> !pending);

    // R5: a full slot only empties when a frame can start
    p_hold_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !fall_tick |=> pending);

    // R6: the slot hands over to the wire in the same cycle
    p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> busy);

    // R11: MDIO pad signals move only after an MDC falling tick
    p_mdio_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(mdio_out) && $stable(mdio_oe));

    // R11: MDC moves only on divider ticks
    p_mdc_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick || fall_tick) |=> $stable(mdc));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pending   (pending_w),
    .busy      (busy_w),
    .mdc       (mdc),
    .rise_tick (rise_tick_w),
    .fall_tick (fall_tick_w),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
// Directed bench for mdio_mgmt_master with a behavioural PHY on the wire.
module mdio_mgmt_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int failures = 0;

    // PHY model state
    int          ones = 0;
    int          fidx = 0;
    bit          active = 0;
    int          pre_ones = 0;
    int          frame_cnt = 0;
    logic [31:0] cap = '0;
    logic [31:0] cap_oe = '0;
    logic [15:0] phy_data = 16'h0000;
    bit          ta_err_inj = 0;
    logic        phy_drive = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_master #(.HALF_DIV(HALF), .PRE_LEN(32)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    // Capture frames on MDC rising edges and plan the PHY's next bit.
    always @(posedge mdc) begin
        if (!active) begin
            if (mdio_oe && mdio_out) ones++;
            else if (mdio_oe && !mdio_out && ones >= 32) begin
                active = 1; pre_ones = ones; fidx = 32;
                cap[31] = 1'b0; cap_oe[31] = 1'b1;
            end else ones = 0;
        end else begin
            fidx++;
            cap[63-fidx]    = mdio_out;
            cap_oe[63-fidx] = mdio_oe;
            if (fidx == 63) begin
                active = 0; ones = 0; frame_cnt++;
            end
        end
        phy_drive = 1'b1;
        if (active && cap[29:28] == 2'b10) begin
            if (fidx + 1 == 47) phy_drive = ta_err_inj;
            else if (fidx + 1 >= 48) phy_drive = phy_data[63-(fidx+1)];
        end
    end

    // PHY presents its bit after MDC falls.
    always @(negedge mdc) mdio_in = phy_drive;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] wd);
        return {1'b1, 1'b0, phy, rg, wd, 1'b0, rd, ~rd, 1'b0};
    endfunction

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            bus_read(4'h0, s);
            if (s[3:2] == 2'b00) return;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(4'h0, v); check("R1 status", v, 0);
        bus_read(4'hC, v); check("R1 result", v, 0);
        check("R1 mdc", mdc, 0);
        check("R1 oe", mdio_oe, 0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int f0 = frame_cnt;
        bus_write(4'h8, mk_cmd(0, 5'h05, 5'h11, 16'hA5C3));
        bus_read(4'h0, v); check("R3 pending set", v, 32'h4);
        wait_idle();
        check("R7 frame count", frame_cnt - f0, 1);
        check("R7 preamble", pre_ones, 32);
        check("R8 write frame", cap, {2'b01, 2'b01, 5'h05, 5'h11, 2'b10, 16'hA5C3});
        check("R8 oe whole frame", cap_oe, 32'hFFFF_FFFF);
        bus_read(4'hC, v); check("R2 result untouched by write", v, 0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] val, input bit err);
        logic [31:0] v;
        phy_data = val; ta_err_inj = err;
        bus_write(4'h8, mk_cmd(1, phy, rg, 16'h0));
        wait_idle();
        check("R7 read header", cap[31:18], {2'b01, 2'b10, phy, rg});
        check("R9 oe released", cap_oe, 32'hFFFC_0000);
        bus_read(4'hC, v);
        if (err) check("R10 error bits", v[31:16], 16'h0003);
        else begin
            check("R9 R12 read data", v[15:0], val);
            check("R10 error clear", v[31:16], 16'h0000);
        end
        ta_err_inj = 0;
    endtask

    task automatic t_queue();
        logic [31:0] v;
        int f0 = frame_cnt;
        bus_write(4'h8, mk_cmd(0, 5'h01, 5'h02, 16'h1111));
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            bus_read(4'h0, v);
            if (v[2] == 1'b0) break;
        end
        check("R6 handoff", v[3:2], 2'b10);
        phy_data = 16'h0F0F;
        bus_write(4'h8, mk_cmd(1, 5'h0A, 5'h04, 16'h0));
        bus_read(4'h0, v); check("R6 accept while busy", v[3:2], 2'b11);
        bus_write(4'h8, mk_cmd(0, 5'h1C, 5'h07, 16'hBEEF));
        wait_idle();
        check("R5 two frames", frame_cnt - f0, 2);
        check("R5 slot kept first", cap[31:18], {2'b01, 2'b10, 5'h0A, 5'h04});
        repeat (600) @(negedge clk);
        check("R5 dropped cmd never sent", frame_cnt - f0, 2);
        bus_read(4'hC, v); check("R12 queued read data", v[15:0], 16'h0F0F);
    endtask

    task automatic t_invalid();
        logic [31:0] v;
        int f0 = frame_cnt;
        bus_write(4'h8, mk_cmd(0, 5'h03, 5'h03, 16'h1) & 32'h7FFF_FFFF);
        bus_read(4'h0, v); check("R4 valid clear", v, 0);
        bus_write(4'h8, mk_cmd(0, 5'h03, 5'h03, 16'h1) | 32'h4);
        bus_read(4'h0, v); check("R4 both ops", v, 0);
        bus_write(4'h8, mk_cmd(0, 5'h03, 5'h03, 16'h1) & ~32'h6);
        bus_read(4'h0, v); check("R4 no op", v, 0);
        bus_write(4'h4, mk_cmd(0, 5'h03, 5'h03, 16'h1));
        bus_read(4'h0, v); check("R2 other offset", v, 0);
        bus_read(4'h4, v); check("R2 unmapped reads 0", v, 0);
        repeat (600) @(negedge clk);
        check("R4 no frame", frame_cnt - f0, 0);
    endtask

    task automatic t_mdc();
        time t0, t1, t2;
        @(posedge mdc); t0 = $time;
        @(negedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        check("R11 mdc high time", t1 - t0, HALF * CLK_PERIOD);
        check("R11 mdc period", t2 - t0, 2 * HALF * CLK_PERIOD);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mdc();
        t_write();
        t_read(5'h1F, 5'h03, 16'h1234, 0);
        t_read(5'h02, 5'h1E, 16'h8001, 1);
        t_read(5'h02, 5'h1E, 16'h7E5A, 0);
        t_queue();
        t_invalid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule